// File: doc/BRIEF.md
# Asynchronous Memory Write Sequencer

This block performs single write accesses from an on-chip requester to external asynchronous memory or memory-mapped peripherals. The requester offers an address, a bank index and a data word with a valid/ready handshake. The sequencer then drives the bank select low and the address onto the external bus. After one setup cycle it pulls the active-low write strobe down. One cycle later it turns on the data driver. It keeps the strobe low until the programmed wait states have run out and the memory's acknowledge, resynchronised to the core clock, is high. Then it releases the bus in a fixed order.

A 5-bit wait configuration input has three fields. Bits [2:0] give the wait-state count W. Bit 3 adds an address hold cycle after the strobe rises. Bit 4 adds a bus idle cycle before the next request may be taken. The configuration is captured when a request is accepted. A one-cycle done pulse marks the last cycle of each access, and that last cycle includes any hold and idle cycles. All timing is counted in whole core clock cycles.

Top module: `async_wr_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, req_ready is 1, mem_wr_n is 1, every mem_sel_n bit is 1, mem_data_oe is 0, mem_addr is 0 and done is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access has finished.
- R3: In the cycle after acceptance, mem_wr_n is still 1 while mem_addr carries the request address and mem_sel_n has only bit b low (b = req_bank). Address and select keep these values for as long as the strobe is low.
- R4: With the acknowledge already high, mem_wr_n stays low for exactly W+2 cycles, where W is cfg_wait[2:0].
- R5: mem_ack passes through two flops before use. If the acknowledge first goes high during low-strobe cycle j (counted from 0), the strobe stays low for max(W+2, j+3) cycles.
- R6: mem_data_oe is 0 in the first low-strobe cycle, 1 in every later low-strobe cycle, and 0 once the strobe is high. While mem_data_oe is 1, mem_data equals the request data.
- R7: After the strobe rises, address and select stay driven for 1 cycle, or for 2 cycles when cfg_wait[3] is 1.
- R8: When cfg_wait[4] is 1, one more cycle with the whole bus released comes before req_ready returns. Counted from the rising strobe, req_ready is therefore 0 for 1 + cfg_wait[3] + cfg_wait[4] cycles.
- R9: done is 1 for exactly one cycle per access: the last cycle before req_ready returns to 1.
- R10: cfg_wait is sampled at acceptance. Changing it during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Write address |
| req_bank | input | BANK_IW | Bank index to select |
| req_data | input | DATA_W | Write data |
| cfg_wait | input | 5 | [2:0] wait count, [3] hold enable, [4] idle enable |
| mem_addr | output | ADDR_W | External address bus (0 when released) |
| mem_sel_n | output | BANKS | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data | output | DATA_W | External data bus value |
| mem_data_oe | output | 1 | Data bus driver enable |
| mem_ack | input | 1 | Asynchronous acknowledge from memory |
| done | output | 1 | One-cycle pulse at the end of an access |

## Verification
The bench uses the default parameters: a 16-bit address, 16-bit data, four banks and a 3-bit wait count. With these values every wait count from 0 to 7 can be programmed, and acknowledge delays both inside and beyond the wait window can be produced. All four hold/idle combinations can be driven, and each bank index can be decoded. Each access records the strobe-low width, the data-enable cycles, the length of the address hold, the gap until ready returns and the cycle in which done appears. These are compared with values the bench computes from the programmed configuration and the delay at which it raises the acknowledge.

// File: rtl/wseq_pkg.sv
// Shared types for the asynchronous write sequencer.
// Assumes: wait configuration layout {idle_en, hold_en, waits}.
package wseq_pkg;
    localparam int WAIT_W = 3;
    localparam int CFG_W  = WAIT_W + 2;

    typedef struct packed {
        logic              idle_en;
        logic              hold_en;
        logic [WAIT_W-1:0] waits;
    } wait_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_ACKW,
        ST_REL,
        ST_HOLD,
        ST_BIDLE
    } wseq_state_e;
endpackage

// File: rtl/wseq_sync.sv
// Multi-flop synchroniser for an asynchronous level input.
// Assumes: the input is a slow level (acknowledge), no pulse capture needed.
module wseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wseq_waitcnt.sv
// Down-counter for the wait-state window of the write strobe.
// Assumes: the owner loads a non-zero value, then steps it down to zero.
module wseq_waitcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load the window length or count it down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= load_val;
        else if (dec && cnt != '0)     cnt <= cnt - CNT_W'(1);
    end

    assign zero = (cnt == '0);

    a_r4_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    a_r4_step_once: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && !zero) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/async_wr_seq.sv
// Bus-master sequencer for single writes to asynchronous external memory.
// Order of phases: setup, strobe low (waits then acknowledge), release,
// optional address hold, optional bus idle. All outputs decode the
// registered state, so they change only on clock edges.
// Assumes: mem_ack is asynchronous and resynchronised here; cfg_wait is
// captured with the request.
module async_wr_seq
    import wseq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BANKS       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BANK_IW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BANK_IW-1:0]   req_bank,
    input  logic [DATA_W-1:0]    req_data,
    input  logic [CFG_W-1:0]     cfg_wait,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BANKS-1:0]     mem_sel_n,
    output logic                 mem_wr_n,
    output logic [DATA_W-1:0]    mem_data,
    output logic                 mem_data_oe,
    input  logic                 mem_ack,
    output logic                 done
);
    localparam int CNT_W = WAIT_W + 1;

    wseq_state_e         state, state_nx;
    logic [ADDR_W-1:0]   addr_q;
    logic [BANK_IW-1:0]  bank_q;
    logic [DATA_W-1:0]   data_q;
    wait_cfg_t           cfg_q;
    logic                ack_s;
    logic                cnt_zero;
    logic                strobe_low;
    logic                low_prev_q;
    logic                addr_phase;
    logic                accept;
    logic [BANKS-1:0]    sel_dec;

    wseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(mem_ack),
        .q_sync (ack_s)
    );

    wseq_waitcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == ST_SETUP),
        .load_val(CNT_W'(cfg_q.waits) + CNT_W'(1)),
        .dec     (state == ST_STROBE),
        .zero    (cnt_zero)
    );

    assign accept = req_valid && (state == ST_IDLE);

    // Capture the request fields and wait configuration on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bank_q <= '0;
            data_q <= '0;
            cfg_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            bank_q <= req_bank;
            data_q <= req_data;
            cfg_q  <= wait_cfg_t'(cfg_wait);
        end
    end

    // Advance the access state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Choose the next phase of the access.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_SETUP;
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: if (cnt_zero) state_nx = ack_s ? ST_REL : ST_ACKW;
            ST_ACKW:   if (ack_s) state_nx = ST_REL;
            ST_REL:    state_nx = cfg_q.hold_en ? ST_HOLD :
                                  (cfg_q.idle_en ? ST_BIDLE : ST_IDLE);
            ST_HOLD:   state_nx = cfg_q.idle_en ? ST_BIDLE : ST_IDLE;
            ST_BIDLE:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign strobe_low = (state == ST_STROBE) || (state == ST_ACKW);

    // Remember whether the strobe was already low last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) low_prev_q <= 1'b0;
        else        low_prev_q <= strobe_low;
    end

    // Decode the bank index into a one-hot select pattern.
    for (genvar b = 0; b < BANKS; b++) begin : g_sel
        assign sel_dec[b] = (bank_q == BANK_IW'(b));
    end

    assign addr_phase  = (state == ST_SETUP) || strobe_low ||
                         (state == ST_REL)   || (state == ST_HOLD);
    assign req_ready   = (state == ST_IDLE);
    assign mem_addr    = addr_phase ? addr_q : '0;
    assign mem_sel_n   = addr_phase ? ~sel_dec : '1;
    assign mem_wr_n    = !strobe_low;
    assign mem_data_oe = strobe_low && low_prev_q;
    assign mem_data    = mem_data_oe ? data_q : '0;
    assign done        = (state == ST_BIDLE) ||
                         ((state == ST_HOLD) && !cfg_q.idle_en) ||
                         ((state == ST_REL) && !cfg_q.hold_en && !cfg_q.idle_en);

    a_r6_oe_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_oe |-> !mem_wr_n);

    a_r6_oe_off_first_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> !mem_data_oe);

    a_r3_sel_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_sel_n != '1));

    a_r3_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $past(mem_sel_n != '1));

    a_r5_rise_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> $past(ack_s));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_wr_n && (mem_sel_n == '1) && !mem_data_oe));

    a_r10_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(cfg_q));
endmodule

// File: tb/async_wr_seq_bench.sv
`timescale 1ns/1ps
module async_wr_seq_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int BANKS  = 4;
    localparam int NVEC   = 9;
    // Vector layout: [11:8] ack raise cycle (F = already high), [4] idle, [3] hold, [2:0] waits
    localparam logic [11:0] VEC [NVEC] = '{
        12'hF00, 12'hF07, 12'h008, 12'h210, 12'h518,
        12'h903, 12'h31E, 12'hF1D, 12'h405
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_bank = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [4:0] cfg_wait = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [BANKS-1:0] mem_sel_n;
    logic mem_wr_n;
    logic [DATA_W-1:0] mem_data;
    logic mem_data_oe;
    logic mem_ack = 1'b0;
    logic done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    async_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)) u_async_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bank(req_bank), .req_data(req_data),
        .cfg_wait(cfg_wait), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_wr_n(mem_wr_n), .mem_data(mem_data), .mem_data_oe(mem_data_oe),
        .mem_ack(mem_ack), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One write access; cfg_after is applied right after acceptance (R10).
    task automatic run_txn(input logic [4:0] cfg, input logic [4:0] cfg_after,
                           input int d, input logic [15:0] addr,
                           input logic [1:0] bank, input logic [15:0] data);
        int w, hold, idle, exp_w, low, gap, acyc, dcnt, dpos;
        bit bad_oe, bad_dat, bad_adr, bad_rdy;
        logic [BANKS-1:0] exp_sel;
        w = int'(cfg[2:0]); hold = int'(cfg[3]); idle = int'(cfg[4]);
        exp_w = (d < 0) ? w + 2 : ((w + 2 > d + 3) ? w + 2 : d + 3);
        exp_sel = ~(BANKS'(1) << bank);
        cfg_wait = cfg; req_addr = addr; req_bank = bank; req_data = data;
        mem_ack = (d < 0); req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; cfg_wait = cfg_after;
        check(!req_ready, "R2 ready low after accept", int'(req_ready), 0);
        check(mem_wr_n && mem_sel_n == exp_sel && mem_addr == addr,
              "R3 setup cycle sel/addr", int'(mem_sel_n), int'(exp_sel));
        low = 0; bad_oe = 0; bad_dat = 0; bad_adr = 0; bad_rdy = 0;
        forever begin
            @(negedge clk);
            if (mem_wr_n || low > 60) break;
            if (mem_data_oe != (low != 0)) bad_oe = 1;
            if (mem_data_oe && mem_data != data) bad_dat = 1;
            if (mem_addr != addr || mem_sel_n != exp_sel) bad_adr = 1;
            if (req_ready) bad_rdy = 1;
            if (d >= 0 && low == d) mem_ack = 1'b1;
            low++;
        end
        check(low == exp_w, (d < 0) ? "R4 strobe width" : "R5 strobe width with ack stall", low, exp_w);
        check(!bad_oe, "R6 data enable pattern", int'(bad_oe), 0);
        check(!bad_dat, "R6 data value", int'(bad_dat), 0);
        check(!bad_adr && !bad_rdy, "R3 addr/sel held during strobe, R2 ready low",
              int'(bad_adr), 0);
        gap = 0; acyc = 0; dcnt = 0; dpos = -1;
        while (!req_ready && gap < 10) begin
            if (mem_sel_n != '1) acyc++;
            if (mem_data_oe) bad_oe = 1;
            if (done) begin dcnt++; dpos = gap; end
            gap++;
            @(negedge clk);
        end
        check(acyc == 1 + hold, "R7 address hold cycles", acyc, 1 + hold);
        check(gap == 1 + hold + idle, "R8 release-to-ready gap", gap, 1 + hold + idle);
        check(dcnt == 1 && dpos == gap - 1, "R9 done pulse position", dpos, gap - 1);
        check(!bad_oe, "R6 data off after strobe rises", int'(bad_oe), 0);
        check(mem_wr_n && mem_sel_n == '1 && !mem_data_oe && mem_addr == '0 && !done,
              "R1 bus released when ready", int'(mem_sel_n), int'({BANKS{1'b1}}));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(req_ready && mem_wr_n && mem_sel_n == '1 && !mem_data_oe &&
              mem_addr == '0 && !done, "R1 reset state", int'(req_ready), 1);
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            int d;
            v = VEC[i];
            d = (v[11:8] == 4'hF) ? -1 : int'(v[11:8]);
            run_txn(v[4:0], v[4:0], d, 16'h1000 + 16'(i * 37), 2'(i),
                    16'hA500 ^ 16'(i * 291));
        end
        // R10: configuration changed mid-access must not alter the access
        run_txn(5'b00001, 5'b11111, -1, 16'hBEEF, 2'd3, 16'h5A5A);
        run_txn(5'b11010, 5'b00000, 6, 16'h0001, 2'd0, 16'hFFFF);
        // R2: request held low leaves the block idle
        repeat (4) @(negedge clk);
        check(req_ready && mem_wr_n && mem_sel_n == '1, "R2 no request stays idle",
              int'(req_ready), 1);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule